// File: doc/BRIEF.md
# Interrupt Status-Word Swap Sequencer

This block carries out the memory side of taking an interrupt for a CPU whose state lives in a 64-bit status word. Six request classes compete for service: machine check, supervisor call, program, external, input/output and restart. When a request wins, the sequencer latches the current status word and the cause information. It stores the status word to the old-status slot reserved for that class. For a supervisor call or a program interrupt it also writes the length code and the 16-bit interruption code into fixed low-memory halfwords with a byte-masked write. It then reads the class's new-status slot and presents that word with a one-cycle load pulse, so the CPU resumes under it.

The memory port is 64 bits wide and word addressed. Byte offset k of a word sits in data bits [63-8k -: 8] and is enabled by byte-enable bit k. Reads return data one cycle after the read strobe. Requesters hold their request lines high until they see their acknowledge pulse. Requests that lose arbitration simply stay pending. Only one swap runs at a time.

Top module: `isq_swap_seq`

## Requirements
- R1: Among eligible requests the winner is chosen by a fixed order: machine check (bit 0), supervisor call (bit 1), program (bit 2), external (bit 3), input/output (bit 4), restart (bit 5). The winner is signalled by a one-cycle, one-hot `irq_ack` pulse on the cycle after the grant edge.
- R2: While `cpu_run` is low, only the restart request (bit 5) can be granted. Any other request gets no acknowledge and causes no memory access.
- R3: The first access of a swap is a full write (`mem_be` = 8'hFF) of the status word sampled at the grant edge. It goes to word address 6 for machine check, 4 for supervisor call, 5 for program, 3 for external, 7 for input/output and 1 for restart (byte addresses 48, 32, 40, 24, 56, 8).
- R4: The new status word is read from word 14 for machine check, 12 for supervisor call, 13 for program, 11 for external, 15 for input/output and 0 for restart. The cycle after the read is idle. On the next cycle `psw_load` is high for exactly one cycle and `new_psw` equals the word that was read. `new_psw` then holds that value.
- R5: A supervisor call writes word 17 (bytes 136-143) with `mem_be` = 8'h0F. Byte offsets 0-1 carry {14'b0, ilc}, and offsets 2-3 carry {8'h00, svc_imm}. Bytes at offsets 4-7 are left unchanged.
- R6: A program interrupt writes word 17 with `mem_be` = 8'hF0. Offsets 4-5 carry {14'b0, ilc}, and offsets 6-7 carry {8'h00, pgm_mon, pgm_cause}, so the concurrent-monitor flag is value bit 7 of the halfword. Offsets 0-3 are left unchanged.
- R7: The classes without a code (machine check, external, input/output, restart) write no code word. For them `psw_load` comes 3 cycles after the `irq_ack` cycle. For supervisor call and program it comes 4 cycles after.
- R8: No new grant occurs until the running swap has pulsed `psw_load`. Pending requests that lost are granted in priority order afterwards, the earliest one cycle after the load pulse. A write and a read never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_run | input | 1 | CPU is in the operating state |
| irq_req | input | 6 | Level requests, one bit per class |
| svc_imm | input | 8 | Immediate field of the supervisor call |
| pgm_cause | input | 7 | Program interruption cause |
| pgm_mon | input | 1 | Concurrent monitoring event flag |
| ilc | input | 2 | Instruction length code |
| cur_psw | input | 64 | Current status word |
| irq_ack | output | 6 | One-hot grant pulse |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Word address |
| mem_be | output | 8 | Byte enables, bit k for byte offset k |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid one cycle after mem_re |
| new_psw | output | 64 | Loaded new status word |
| psw_load | output | 1 | One-cycle pulse when new_psw is loaded |

## Verification
The assertions take for granted that memory answers a read with exactly one cycle of latency. They also assume a requester keeps its line high until acknowledged and does not raise it again for the same event. The priority and stopped-state properties further assume that `cpu_run` and `irq_req` are stable across the grant edge. The stimulus drives every input on the falling edge. It drops each request bit on the cycle its acknowledge is seen and leaves losing requests asserted. It changes `cpu_run` only while no swap is in progress.

// File: rtl/isq_pkg.sv
package isq_pkg;
   localparam int NCLS   = 6;
   localparam int PSW_W  = 64;
   localparam int BE_W   = PSW_W / 8;
   localparam logic [4:0] CODE_WORD = 5'd17;

   typedef enum logic [2:0] {
      CLS_MCK = 3'd0,
      CLS_SVC = 3'd1,
      CLS_PGM = 3'd2,
      CLS_EXT = 3'd3,
      CLS_IO  = 3'd4,
      CLS_RST = 3'd5
   } cls_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_OLD, ST_CODE, ST_FETCH, ST_WAIT
   } st_e;

   function automatic logic [4:0] old_word(cls_e c);
      case (c)
         CLS_MCK: return 5'd6;
         CLS_SVC: return 5'd4;
         CLS_PGM: return 5'd5;
         CLS_EXT: return 5'd3;
         CLS_IO:  return 5'd7;
         default: return 5'd1;
      endcase
   endfunction

   function automatic logic [4:0] new_word(cls_e c);
      case (c)
         CLS_MCK: return 5'd14;
         CLS_SVC: return 5'd12;
         CLS_PGM: return 5'd13;
         CLS_EXT: return 5'd11;
         CLS_IO:  return 5'd15;
         default: return 5'd0;
      endcase
   endfunction
endpackage

// File: rtl/isq_arbiter.sv
module isq_arbiter
   import isq_pkg::*;
#(
   parameter int N = NCLS
) (
   input  logic [N-1:0] req,
   input  logic         cpu_run,
   output logic [N-1:0] win,
   output logic [2:0]   win_idx,
   output logic         any
);
   localparam logic [N-1:0] RST_MASK = N'(1) << CLS_RST;

   logic [N-1:0] elig;
   logic [N:0]   taken;

   assign elig     = cpu_run ? req : (req & RST_MASK);
   assign taken[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_pri
      assign win[i]     = elig[i] & ~taken[i];
      assign taken[i+1] = taken[i] | elig[i];
   end

   assign any = taken[N];

   always_comb begin
      win_idx = 3'd0;
      for (int i = N - 1; i >= 0; i--) begin
         if (win[i]) win_idx = 3'(i);
      end
   end
endmodule

// File: rtl/isq_lowmem.sv
module isq_lowmem
   import isq_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  cls_e              cls,
   input  logic [1:0]        ilc,
   input  logic [7:0]        imm,
   input  logic [6:0]        cause,
   input  logic              mon,
   output logic [ADDR_W-1:0] old_addr,
   output logic [ADDR_W-1:0] new_addr,
   output logic [ADDR_W-1:0] code_addr,
   output logic [PSW_W-1:0]  code_data,
   output logic [BE_W-1:0]   code_be,
   output logic              has_code
);
   logic [15:0] ilc_half;

   assign ilc_half  = {14'b0, ilc};
   assign old_addr  = ADDR_W'(old_word(cls));
   assign new_addr  = ADDR_W'(new_word(cls));
   assign code_addr = ADDR_W'(CODE_WORD);
   assign has_code  = (cls == CLS_SVC) || (cls == CLS_PGM);

   always_comb begin
      if (cls == CLS_SVC) begin
         code_data = {ilc_half, 8'h00, imm, 32'h0};
         code_be   = 8'h0F;
      end else begin
         code_data = {32'h0, ilc_half, 8'h00, mon, cause};
         code_be   = 8'hF0;
      end
   end
endmodule

// File: rtl/isq_swap_seq.sv
module isq_swap_seq
   import isq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int WORD_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_run,
   input  logic [5:0]        irq_req,
   input  logic [7:0]        svc_imm,
   input  logic [6:0]        pgm_cause,
   input  logic              pgm_mon,
   input  logic [1:0]        ilc,
   input  logic [63:0]       cur_psw,
   output logic [5:0]        irq_ack,
   output logic              mem_we,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_be,
   output logic [63:0]       mem_wdata,
   input  logic [63:0]       mem_rdata,
   output logic [63:0]       new_psw,
   output logic              psw_load
);
   if (ADDR_W < 5) begin : g_bad_addr
      $error("isq_swap_seq: ADDR_W must reach word 17");
   end
   if (WORD_W != PSW_W) begin : g_bad_word
      $error("isq_swap_seq: WORD_W must equal the status word width");
   end

   st_e               state;
   cls_e              cls_q;
   logic [PSW_W-1:0]  psw_q, new_q;
   logic [7:0]        imm_q;
   logic [6:0]        cause_q;
   logic              mon_q, load_q;
   logic [1:0]        ilc_q;
   logic [NCLS-1:0]   ack_q, arb_win;
   logic [2:0]        arb_idx;
   logic              arb_any, has_code;
   logic [ADDR_W-1:0] old_addr, new_addr, code_addr;
   logic [PSW_W-1:0]  code_data;
   logic [BE_W-1:0]   code_be;

   isq_arbiter #(.N(NCLS)) u_arb (
      .req     (irq_req),
      .cpu_run (cpu_run),
      .win     (arb_win),
      .win_idx (arb_idx),
      .any     (arb_any)
   );

   isq_lowmem #(.ADDR_W(ADDR_W)) u_lm (
      .cls       (cls_q),
      .ilc       (ilc_q),
      .imm       (imm_q),
      .cause     (cause_q),
      .mon       (mon_q),
      .old_addr  (old_addr),
      .new_addr  (new_addr),
      .code_addr (code_addr),
      .code_data (code_data),
      .code_be   (code_be),
      .has_code  (has_code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cls_q   <= CLS_MCK;
         psw_q   <= '0;
         new_q   <= '0;
         imm_q   <= '0;
         cause_q <= '0;
         mon_q   <= 1'b0;
         ilc_q   <= '0;
         ack_q   <= '0;
         load_q  <= 1'b0;
      end else begin
         ack_q  <= '0;
         load_q <= 1'b0;
         case (state)
            ST_IDLE: if (arb_any) begin
               state   <= ST_OLD;
               ack_q   <= arb_win;
               cls_q   <= cls_e'(arb_idx);
               psw_q   <= cur_psw;
               imm_q   <= svc_imm;
               cause_q <= pgm_cause;
               mon_q   <= pgm_mon;
               ilc_q   <= ilc;
            end
            ST_OLD:   state <= has_code ? ST_CODE : ST_FETCH;
            ST_CODE:  state <= ST_FETCH;
            ST_FETCH: state <= ST_WAIT;
            ST_WAIT: begin
               state  <= ST_IDLE;
               new_q  <= mem_rdata;
               load_q <= 1'b1;
            end
            default:  state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      mem_addr  = '0;
      mem_be    = '0;
      mem_wdata = '0;
      case (state)
         ST_OLD: begin
            mem_we    = 1'b1;
            mem_addr  = old_addr;
            mem_be    = '1;
            mem_wdata = psw_q;
         end
         ST_CODE: begin
            mem_we    = 1'b1;
            mem_addr  = code_addr;
            mem_be    = code_be;
            mem_wdata = code_data;
         end
         ST_FETCH: begin
            mem_re   = 1'b1;
            mem_addr = new_addr;
         end
         default: ;
      endcase
   end

   assign irq_ack  = ack_q;
   assign new_psw  = new_q;
   assign psw_load = load_q;
endmodule

// File: rtl/isq_swap_seq_chk.sv
module isq_swap_seq_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_run,
   input logic [5:0]        irq_req,
   input logic [5:0]        irq_ack,
   input logic              mem_we,
   input logic              mem_re,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [7:0]        mem_be,
   input logic [63:0]       mem_rdata,
   input logic [63:0]       new_psw,
   input logic              psw_load
);
   logic busy;

   always_ff @(posedge clk) begin
      if (!rst_n)             busy <= 1'b0;
      else if (irq_ack != '0) busy <= 1'b1;
      else if (psw_load)      busy <= 1'b0;
   end

   assert_ack_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack));

   assert_ack_priority_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack != '0) && $past(cpu_run) |-> (($past(irq_req) & (irq_ack - 6'd1)) == '0));

   assert_stopped_restart_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack != '0) && !$past(cpu_run) |-> irq_ack == 6'b100000);

   assert_read_then_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> !mem_re && !mem_we);

   assert_load_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      psw_load |-> $past(mem_re, 2) && new_psw == $past(mem_rdata));

   assert_load_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      psw_load |=> !psw_load);

   assert_masked_write_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we && mem_be != 8'hFF |-> mem_addr == ADDR_W'(17) && (mem_be == 8'h0F || mem_be == 8'hF0));

   assert_no_grant_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack != '0) |-> !busy);

   assert_no_we_re_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));
endmodule

bind isq_swap_seq isq_swap_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_run   (cpu_run),
   .irq_req   (irq_req),
   .irq_ack   (irq_ack),
   .mem_we    (mem_we),
   .mem_re    (mem_re),
   .mem_addr  (mem_addr),
   .mem_be    (mem_be),
   .mem_rdata (mem_rdata),
   .new_psw   (new_psw),
   .psw_load  (psw_load)
);

// File: tb/isq_swap_seq_tb.sv
module isq_swap_seq_tb;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_run = 1'b1;
   logic [5:0]    irq_req = '0;
   logic [7:0]    svc_imm = '0;
   logic [6:0]    pgm_cause = '0;
   logic          pgm_mon = 1'b0;
   logic [1:0]    ilc = '0;
   logic [63:0]   cur_psw = '0;
   logic [5:0]    irq_ack;
   logic          mem_we, mem_re, psw_load;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_be;
   logic [63:0]   mem_wdata, new_psw;
   logic [63:0]   mem_rdata = '0;
   logic [63:0]   mem [0:31];

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   isq_swap_seq #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_run(cpu_run), .irq_req(irq_req),
      .svc_imm(svc_imm), .pgm_cause(pgm_cause), .pgm_mon(pgm_mon), .ilc(ilc),
      .cur_psw(cur_psw), .irq_ack(irq_ack), .mem_we(mem_we), .mem_re(mem_re),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .new_psw(new_psw), .psw_load(psw_load)
   );

   function automatic logic [63:0] be_mask(input logic [7:0] be);
      logic [63:0] m = '0;
      for (int k = 0; k < 8; k++) if (be[k]) m[63-8*k -: 8] = 8'hFF;
      return m;
   endfunction

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[4:0]] <= (mem[mem_addr[4:0]] & ~be_mask(mem_be)) |
                                        (mem_wdata & be_mask(mem_be));
      if (mem_re) mem_rdata <= mem[mem_addr[4:0]];
   end

   function automatic int old_w(input int c);
      int t[6] = '{6, 4, 5, 3, 7, 1};
      return t[c];
   endfunction
   function automatic int new_w(input int c);
      int t[6] = '{14, 12, 13, 11, 15, 0};
      return t[c];
   endfunction
   function automatic logic [63:0] new_val(input int c);
      return {32'hC0DE_0000 + 32'(c), 32'h1234_5670 + 32'(c)};
   endfunction
   function automatic int pick(input logic [5:0] r, input logic run);
      if (!run) return r[5] ? 5 : -1;
      for (int i = 0; i < 6; i++) if (r[i]) return i;
      return -1;
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // One clock of the reference model: compare every output at the falling edge
   task automatic step(input logic [5:0] eack, input logic ewe, input logic ere,
                       input int eaddr, input logic [7:0] ebe, input logic [63:0] ewd,
                       input logic eload, input logic [63:0] epsw, input string rq);
      @(negedge clk);
      chk(irq_ack == eack, {rq, " ack"}, 64'(irq_ack), 64'(eack));
      chk(mem_we == ewe && mem_re == ere, {rq, " strobes"}, {mem_we, mem_re}, {ewe, ere});
      chk(psw_load == eload, {rq, " load"}, 64'(psw_load), 64'(eload));
      if (ewe || ere) chk(mem_addr == AW'(eaddr), {rq, " addr"}, 64'(mem_addr), 64'(eaddr));
      if (ewe) begin
         chk(mem_be == ebe, {rq, " be"}, 64'(mem_be), 64'(ebe));
         chk((mem_wdata & be_mask(ebe)) == (ewd & be_mask(ebe)), {rq, " wdata"},
             mem_wdata & be_mask(ebe), ewd & be_mask(ebe));
      end
      if (eload) chk(new_psw == epsw, {rq, " new_psw"}, new_psw, epsw);
   endtask

   task automatic serve(input logic [5:0] req0, input logic run, input int idle_after);
      logic [5:0]  pend = req0;
      logic [63:0] psw;
      logic [63:0] cd;
      int c;
      irq_req = pend;
      cpu_run = run;
      c = pick(pend, run);
      while (c >= 0) begin
         psw = cur_psw;
         step(6'(1) << c, 1'b1, 1'b0, old_w(c), 8'hFF, psw, 1'b0, '0,
              c == 5 ? "R3 R2 old store" : "R1 R3 old store");
         pend[c] = 1'b0;
         irq_req = pend;
         cur_psw = ~psw;
         svc_imm = ~svc_imm;
         if (c == 1 || c == 2) begin
            if (c == 1) cd = {14'b0, ilc, 8'h00, ~svc_imm, 32'h0};
            else        cd = {32'h0, 14'b0, ilc, 8'h00, pgm_mon, pgm_cause};
            step('0, 1'b1, 1'b0, 17, c == 1 ? 8'h0F : 8'hF0, cd, 1'b0, '0,
                 c == 1 ? "R5 svc code" : "R6 pgm code");
         end
         step('0, 1'b0, 1'b1, new_w(c), '0, '0, 1'b0, '0, "R4 fetch");
         step('0, 1'b0, 1'b0, 0, '0, '0, 1'b0, '0, "R4 wait");
         step('0, 1'b0, 1'b0, 0, '0, '0, 1'b1, new_val(c), "R4 R7 load");
         cur_psw = psw;
         svc_imm = ~svc_imm;
         c = pick(pend, run);
      end
      for (int i = 0; i < idle_after; i++)
         step('0, 1'b0, 1'b0, 0, '0, '0, 1'b0, '0, "R2 R8 idle");
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) mem[i] = 64'hFFFF_FFFF_FFFF_FFFF;
      for (int c = 0; c < 6; c++) mem[new_w(c)] = new_val(c);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      step('0, 1'b0, 1'b0, 0, '0, '0, 1'b0, '0, "R8 reset");

      // supervisor call alone
      cur_psw = 64'h0123_4567_89AB_CDEF; svc_imm = 8'h5A; ilc = 2'd1;
      serve(6'b000010, 1'b1, 1);
      chk(mem[4] == 64'h0123_4567_89AB_CDEF, "R3 svc old word", mem[4], 64'h0123_4567_89AB_CDEF);
      chk(mem[17] == 64'h0001_005A_FFFF_FFFF, "R5 svc code word", mem[17], 64'h0001_005A_FFFF_FFFF);

      // program interrupt with monitor flag, page-transition cause
      mem[17] = 64'hFFFF_FFFF_FFFF_FFFF;
      cur_psw = 64'hFEDC_BA98_7654_3210; pgm_cause = 7'h1B; pgm_mon = 1'b1; ilc = 2'd2;
      serve(6'b000100, 1'b1, 1);
      chk(mem[17] == 64'hFFFF_FFFF_0002_009B, "R6 pgm code word", mem[17], 64'hFFFF_FFFF_0002_009B);
      chk(mem[5] == 64'hFEDC_BA98_7654_3210, "R3 pgm old word", mem[5], 64'hFEDC_BA98_7654_3210);

      // program without flag, specification cause
      pgm_cause = 7'h06; pgm_mon = 1'b0; ilc = 2'd3;
      serve(6'b000100, 1'b1, 1);
      chk(mem[17] == 64'hFFFF_FFFF_0003_0006, "R6 pgm code no flag", mem[17], 64'hFFFF_FFFF_0003_0006);

      // external alone: no code write
      mem[17] = 64'h1111_2222_3333_4444;
      cur_psw = 64'hAAAA_0000_5555_0001;
      serve(6'b001000, 1'b1, 1);
      chk(mem[17] == 64'h1111_2222_3333_4444, "R7 no code write", mem[17], 64'h1111_2222_3333_4444);
      chk(new_psw == new_val(3), "R4 new_psw holds", new_psw, new_val(3));

      // simultaneous requests served in priority order
      cur_psw = 64'h0000_1111_2222_3333;
      serve(6'b111111, 1'b1, 2);
      chk(mem[6] == 64'h0000_1111_2222_3333, "R1 mck served", mem[6], 64'h0000_1111_2222_3333);
      chk(mem[1] == 64'h0000_1111_2222_3333, "R8 restart served last", mem[1], 64'h0000_1111_2222_3333);

      // stopped CPU: external and I/O ignored
      mem[3] = '0; mem[7] = '0;
      serve(6'b011000, 1'b0, 6);
      chk(mem[3] == '0 && mem[7] == '0, "R2 stopped ignored", {mem[3][31:0], mem[7][31:0]}, '0);
      // restart is taken while stopped, others stay pending
      cur_psw = 64'h5555_6666_7777_8888;
      serve(6'b111000, 1'b0, 4);
      chk(mem[1] == 64'h5555_6666_7777_8888, "R2 restart while stopped", mem[1], 64'h5555_6666_7777_8888);
      // running again: pending ones served in order
      serve(6'b011000, 1'b1, 1);
      chk(mem[7] == 64'h5555_6666_7777_8888, "R8 held io served", mem[7], 64'h5555_6666_7777_8888);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule